// File: doc/BRIEF.md
# Serial EEPROM Boot Configuration Loader

This block runs once after reset. It reads a small serial EEPROM of 16-bit words over a four-wire link: chip select, serial clock, command/address out and data in. From that device it collects the identity and start-up settings that the rest of the chip needs. Word 0 must hold a 12-bit signature. Its low nibble carries the string-enable flags. When the signature is present, the block goes on to read the vendor ID, the product ID, a feature-flag word and a volume word.

When the signature is absent, the block stops reading and presents hardwired defaults. The signature is absent when the data line floats high because no device is fitted, and also when any other value is read. Volume codes read from the EEPROM are clamped into their legal ranges. All configuration outputs keep their default values until a single cycle in which the loaded set is published. In that same cycle `done` rises, and it then stays high.

Top module: `mwcfg_loader`

## Requirements
- R1: From reset until `done` rises, the outputs hold the defaults: vendor 0x0D8C, product 0x0139, manufacturer string on, product string on, serial string off, serial data valid off, features 0x02A, playback volume 0x1E, record volume 0x3C. `done` is low during this time.
- R2: Each word read keeps chip select high for the whole read. It first sends a start bit 1, then opcode bits 1 and 0, then the 6-bit word address MSB first. The address output changes only while the serial clock is low. On the following rising edges the block samples one dummy bit and then 16 data bits, MSB first.
- R3: Within a read, the serial clock period is exactly DIV system clocks. The serial clock is low whenever chip select is low. Between two reads, chip select stays low for at least DIV system clocks.
- R4: Word 0 counts as valid only when bits 15..4 equal 0x670. For any other value the block makes no further reads, keeps the R1 defaults and raises `done`.
- R5: With no device fitted, the data line reads all ones. Exactly one read (address 0) takes place, and the R1 defaults result.
- R6: For a valid word 0, reads follow in the order of addresses 0, 1, 2, FLAG_ADDR (default 3) and VOL_ADDR (default 4). Word 1 becomes the vendor ID and word 2 becomes the product ID.
- R7: The word 0 low nibble maps to the outputs as follows: bit 3 to serial data valid, bit 2 to manufacturer string enable, bit 1 to serial string enable, bit 0 to product string enable.
- R8: The feature output is bits 8..0 of the flag word, with bit 6 (reserved) forced to 0. The bit meanings are: 8 DAC shutdown, 7 power control, 5 mic high-pass, 4 ADC sync, 3 mic boost, 2 headset terminal, 1 HID, 0 remote wakeup.
- R9: The playback volume is taken from bits 14..8 of the volume word and clamped to 0x02..0x4A.
- R10: The record volume is taken from bits 6..0 of the volume word and clamped to 0x00..0x78. Bits 15 and 7 of the volume word are ignored.
- R11: `done` stays high once set. The loaded values appear in the same cycle that `done` rises and do not change afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; loading starts on release |
| ee_cs | output | 1 | EEPROM chip select, active high |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_do | output | 1 | Command/address bit to the EEPROM |
| ee_di | input | 1 | Data bit from the EEPROM |
| done | output | 1 | Configuration valid, sticky |
| vid | output | 16 | Vendor ID |
| pid | output | 16 | Product ID |
| mfr_str_en | output | 1 | Manufacturer string enable |
| ser_str_en | output | 1 | Serial number string enable |
| prod_str_en | output | 1 | Product string enable |
| ser_data_valid | output | 1 | Serial-number data valid flag |
| feat | output | 9 | Feature flags |
| play_vol | output | 7 | Initial playback volume code |
| rec_vol | output | 7 | Initial record volume code |

## Verification
The bench builds the loader with DIV set to 4 and keeps the default addresses and defaults. At that divider a full five-word load takes only a few hundred cycles. This makes it practical to reset and reload once for every one of the 16 string-enable nibbles, for both kinds of bad signature and for the empty socket. The volume codes in those loads walk through each clamp edge: playback values just below, at and above 0x02 and 0x4A, and record values around 0x78. An EEPROM model in the bench decodes each command and checks its address sequence, while monitors measure the clock period and the gap in chip select.

// File: rtl/mwcfg_pkg.sv
package mwcfg_pkg;

    localparam int ID_W   = 16;
    localparam int FEAT_W = 9;
    localparam int VOL_W  = 7;

    typedef struct packed {
        logic [ID_W-1:0]   vid;
        logic [ID_W-1:0]   pid;
        logic              mfr_en;
        logic              ser_en;
        logic              prod_en;
        logic              ser_valid;
        logic [FEAT_W-1:0] feat;
        logic [VOL_W-1:0]  play;
        logic [VOL_W-1:0]  rec;
    } cfg_t;

    typedef enum logic [1:0] {X_IDLE, X_SHIFT, X_GAP} xfer_st_e;
    typedef enum logic [1:0] {T_ISSUE, T_WAIT, T_DONE} seq_st_e;

endpackage

// File: rtl/mwcfg_tick.sv
module mwcfg_tick #(
    parameter int HALF = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic half
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        half  = (cnt_q == CW'(HALF - 1));
        cnt_d = cnt_q + 1'b1;
        if (clr || half) cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    generate
        if (HALF > 1) begin : g_spacing
            // R3: half-period pulses never come back to back
            a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
                half |=> !half);
        end
    endgenerate

endmodule

// File: rtl/mwcfg_sat.sv
module mwcfg_sat #(
    parameter int W  = 7,
    parameter int LO = 0,
    parameter int HI = 127
) (
    input  logic [W-1:0] raw,
    output logic [W-1:0] sat
);
    always_comb begin
        if (raw < W'(LO))      sat = W'(LO);
        else if (raw > W'(HI)) sat = W'(HI);
        else                   sat = raw;
    end
endmodule

// File: rtl/mwcfg_xfer.sv
module mwcfg_xfer
    import mwcfg_pkg::*;
#(
    parameter int AW   = 6,
    parameter int DW   = 16,
    parameter int HALF = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic          di,
    output logic          cs,
    output logic          sk,
    output logic          dout,
    output logic          fin,
    output logic [DW-1:0] data
);
    localparam int CMDW = 3 + AW;
    localparam int TB   = CMDW + 1 + DW;
    localparam int IW   = $clog2(TB);

    typedef struct packed {
        xfer_st_e        st;
        logic            cs;
        logic            sk;
        logic            dout;
        logic [CMDW-1:0] cmd;
        logic [IW-1:0]   idx;
        logic [DW-1:0]   sh;
        logic            gap;
        logic            fin;
    } xs_t;

    xs_t  s_d, s_q;
    logic half, tclr;

    mwcfg_tick #(.HALF(HALF)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (tclr),
        .half (half)
    );

    always_comb begin
        s_d     = s_q;
        s_d.fin = 1'b0;
        tclr    = 1'b0;
        case (s_q.st)
            X_IDLE: begin
                if (start) begin
                    s_d.st   = X_SHIFT;
                    s_d.cs   = 1'b1;
                    s_d.sk   = 1'b0;
                    s_d.cmd  = {3'b110, addr};
                    s_d.dout = 1'b1;
                    s_d.idx  = '0;
                    tclr     = 1'b1;
                end
            end
            X_SHIFT: begin
                if (half) begin
                    if (!s_q.sk) begin
                        s_d.sk = 1'b1;
                        if (s_q.idx >= IW'(CMDW)) s_d.sh = {s_q.sh[DW-2:0], di};
                    end else begin
                        s_d.sk = 1'b0;
                        if (s_q.idx == IW'(TB - 1)) begin
                            s_d.st   = X_GAP;
                            s_d.cs   = 1'b0;
                            s_d.dout = 1'b0;
                            s_d.gap  = 1'b0;
                        end else begin
                            s_d.idx  = s_q.idx + 1'b1;
                            s_d.cmd  = {s_q.cmd[CMDW-2:0], 1'b0};
                            s_d.dout = ((s_q.idx + 1'b1) < IW'(CMDW)) ? s_q.cmd[CMDW-2] : 1'b0;
                        end
                    end
                end
            end
            X_GAP: begin
                if (half) begin
                    if (s_q.gap) begin
                        s_d.st  = X_IDLE;
                        s_d.fin = 1'b1;
                    end else begin
                        s_d.gap = 1'b1;
                    end
                end
            end
            default: s_d.st = X_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: X_IDLE, cs: 1'b0, sk: 1'b0, dout: 1'b0, cmd: '0,
                     idx: '0, sh: '0, gap: 1'b0, fin: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign cs   = s_q.cs;
    assign sk   = s_q.sk;
    assign dout = s_q.dout;
    assign fin  = s_q.fin;
    assign data = s_q.sh;

    // R3: the serial clock rests low outside a selected read
    a_r3_sk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.cs |-> !s_q.sk);
    // R2: address bit is held across the high phase of the serial clock
    a_r2_do_held_high: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.sk |=> (!s_q.sk || $stable(s_q.dout)));
    // R2: a new read is only accepted when idle
    a_r2_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (s_q.st == X_IDLE));

endmodule

// File: rtl/mwcfg_loader.sv
module mwcfg_loader
    import mwcfg_pkg::*;
#(
    parameter int          DIV       = 64,
    parameter int          AW        = 6,
    parameter int          FLAG_ADDR = 3,
    parameter int          VOL_ADDR  = 4,
    parameter logic [11:0] SIG       = 12'h670,
    parameter logic [15:0] DEF_VID   = 16'h0D8C,
    parameter logic [15:0] DEF_PID   = 16'h0139,
    parameter logic [6:0]  DEF_PLAY  = 7'h1E,
    parameter logic [6:0]  DEF_REC   = 7'h3C
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic        ee_cs,
    output logic        ee_sk,
    output logic        ee_do,
    input  logic        ee_di,
    output logic        done,
    output logic [15:0] vid,
    output logic [15:0] pid,
    output logic        mfr_str_en,
    output logic        ser_str_en,
    output logic        prod_str_en,
    output logic        ser_data_valid,
    output logic [8:0]  feat,
    output logic [6:0]  play_vol,
    output logic [6:0]  rec_vol
);
    localparam int          HALF      = DIV / 2;
    localparam int          PLAY_LO   = 2;
    localparam int          PLAY_HI   = 'h4A;
    localparam int          REC_HI    = 'h78;
    localparam int          LAST_STEP = 4;
    localparam logic [8:0]  FEAT_DEF  = 9'h02A;
    localparam logic [8:0]  FEAT_MASK = 9'h1BF;

    localparam cfg_t CFG_DEF = '{vid: DEF_VID, pid: DEF_PID, mfr_en: 1'b1, ser_en: 1'b0,
                                 prod_en: 1'b1, ser_valid: 1'b0, feat: FEAT_DEF,
                                 play: DEF_PLAY, rec: DEF_REC};

    typedef struct packed {
        seq_st_e     st;
        logic [2:0]  step;
        logic [3:0]  nib;
        logic [15:0] vid;
        logic [15:0] pid;
        logic [8:0]  flg;
        cfg_t        cfg;
        logic        done;
    } ls_t;

    ls_t           s_d, s_q;
    logic          xstart, xfin;
    logic [AW-1:0] xaddr;
    logic [15:0]   xdata;
    logic [6:0]    play_sat, rec_sat;

    mwcfg_xfer #(.AW(AW), .DW(16), .HALF(HALF)) u_xfer (
        .clk  (clk),
        .rst_n(rst_n),
        .start(xstart),
        .addr (xaddr),
        .di   (ee_di),
        .cs   (ee_cs),
        .sk   (ee_sk),
        .dout (ee_do),
        .fin  (xfin),
        .data (xdata)
    );

    mwcfg_sat #(.W(7), .LO(PLAY_LO), .HI(PLAY_HI)) u_sat_play (
        .raw(xdata[14:8]),
        .sat(play_sat)
    );

    mwcfg_sat #(.W(7), .LO(0), .HI(REC_HI)) u_sat_rec (
        .raw(xdata[6:0]),
        .sat(rec_sat)
    );

    always_comb begin
        case (s_q.step)
            3'd0:    xaddr = '0;
            3'd1:    xaddr = AW'(1);
            3'd2:    xaddr = AW'(2);
            3'd3:    xaddr = AW'(FLAG_ADDR);
            default: xaddr = AW'(VOL_ADDR);
        endcase
    end

    assign xstart = (s_q.st == T_ISSUE);

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            T_ISSUE: s_d.st = T_WAIT;
            T_WAIT: begin
                if (xfin) begin
                    s_d.step = s_q.step + 1'b1;
                    s_d.st   = T_ISSUE;
                    case (s_q.step)
                        3'd0: begin
                            if (xdata[15:4] != SIG) begin
                                s_d.st   = T_DONE;
                                s_d.done = 1'b1;
                            end else begin
                                s_d.nib = xdata[3:0];
                            end
                        end
                        3'd1: s_d.vid = xdata;
                        3'd2: s_d.pid = xdata;
                        3'd3: s_d.flg = xdata[8:0] & FEAT_MASK;
                        default: begin
                            s_d.st            = T_DONE;
                            s_d.done          = 1'b1;
                            s_d.cfg.vid       = s_q.vid;
                            s_d.cfg.pid       = s_q.pid;
                            s_d.cfg.ser_valid = s_q.nib[3];
                            s_d.cfg.mfr_en    = s_q.nib[2];
                            s_d.cfg.ser_en    = s_q.nib[1];
                            s_d.cfg.prod_en   = s_q.nib[0];
                            s_d.cfg.feat      = s_q.flg;
                            s_d.cfg.play      = play_sat;
                            s_d.cfg.rec       = rec_sat;
                        end
                    endcase
                end
            end
            default: s_d.st = T_DONE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: T_ISSUE, step: '0, nib: '0, vid: '0, pid: '0,
                     flg: '0, cfg: CFG_DEF, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign done           = s_q.done;
    assign vid            = s_q.cfg.vid;
    assign pid            = s_q.cfg.pid;
    assign mfr_str_en     = s_q.cfg.mfr_en;
    assign ser_str_en     = s_q.cfg.ser_en;
    assign prod_str_en    = s_q.cfg.prod_en;
    assign ser_data_valid = s_q.cfg.ser_valid;
    assign feat           = s_q.cfg.feat;
    assign play_vol       = s_q.cfg.play;
    assign rec_vol        = s_q.cfg.rec;

    // R11: done never falls once raised
    a_r11_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> s_q.done);
    // R11: published configuration is frozen after done
    a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |=> $stable(s_q.cfg));
    // R1: configuration only moves in the cycle done rises
    a_r1_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.done |=> (s_q.done || $stable(s_q.cfg)));
    // R4: no read is started after loading ends
    a_r4_no_read_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !xstart);
    // R9: playback volume within legal range
    a_r9_play_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (play_vol >= 7'(PLAY_LO) && play_vol <= 7'(PLAY_HI)));
    // R10: record volume within legal range
    a_r10_rec_range: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> (rec_vol <= 7'(REC_HI)));
    // R8: reserved feature bit stays clear
    a_r8_reserved_clear: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.done |-> !feat[6]);

endmodule

// File: tb/mwcfg_loader_test.sv
module mwcfg_loader_test;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ee_cs, ee_sk, ee_do, ee_di;
    logic        done;
    logic [15:0] vid, pid;
    logic        mfr_str_en, ser_str_en, prod_str_en, ser_data_valid;
    logic [8:0]  feat;
    logic [6:0]  play_vol, rec_vol;

    always #2.5 clk = ~clk;

    mwcfg_loader #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_do(ee_do),
        .ee_di(ee_di), .done(done), .vid(vid), .pid(pid), .mfr_str_en(mfr_str_en),
        .ser_str_en(ser_str_en), .prod_str_en(prod_str_en),
        .ser_data_valid(ser_data_valid), .feat(feat), .play_vol(play_vol),
        .rec_vol(rec_vol)
    );

    int nvec = 0;
    int nfail = 0;

    // EEPROM model
    logic [15:0] mem [0:63];
    bit          present = 1'b0;
    logic        di_r = 1'b1;
    logic [8:0]  cmd = '0;
    int          bc = 0;
    int          ntx = 0;
    int          cmd_err = 0;
    int          order_err = 0;

    assign ee_di = present ? di_r : 1'b1;

    function automatic logic [5:0] exp_addr(int n);
        case (n)
            0: return 6'd0;
            1: return 6'd1;
            2: return 6'd2;
            3: return 6'd3;
            default: return 6'd4;
        endcase
    endfunction

    always @(posedge ee_sk or negedge ee_cs) begin
        if (!ee_cs) begin
            bc   = 0;
            di_r = 1'b1;
        end else begin
            bc = bc + 1;
            if (bc <= 9) cmd = {cmd[7:0], ee_do};
            if (bc == 9) begin
                // R2: start bit then read opcode
                if (cmd[8:6] != 3'b110) cmd_err++;
                // R6: address sequence
                if (ntx > 4 || cmd[5:0] != exp_addr(ntx)) order_err++;
                ntx++;
                di_r = 1'b0;
            end else if (bc >= 10 && bc <= 25) begin
                di_r = mem[cmd[5:0]][25 - bc];
            end
        end
    end

    // R3 monitors: clock period and chip-select gap
    int per_err = 0, gap_err = 0;
    int since_rise = 0, gap_cnt = 0;
    bit have_rise = 0, seen_cs = 0;
    logic sk_prev = 1'b0, cs_prev = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            have_rise = 0; seen_cs = 0; gap_cnt = 0; since_rise = 0;
        end else begin
            if (ee_sk && !sk_prev) begin
                if (have_rise && since_rise != DIV) per_err++;
                since_rise = 1;
                have_rise  = 1;
            end else begin
                since_rise++;
            end
            if (!ee_cs) begin
                have_rise = 0;
                gap_cnt++;
                if (ee_sk) per_err++;
            end
            if (ee_cs && !cs_prev) begin
                if (seen_cs && gap_cnt < DIV) gap_err++;
                seen_cs = 1;
                gap_cnt = 0;
            end
        end
        sk_prev = ee_sk;
        cs_prev = ee_cs;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [6:0] play_exp(logic [15:0] v);
        logic [6:0] r = v[14:8];
        if (r < 7'h02) return 7'h02;
        if (r > 7'h4A) return 7'h4A;
        return r;
    endfunction

    function automatic logic [6:0] rec_exp(logic [15:0] v);
        logic [6:0] r = v[6:0];
        if (r > 7'h78) return 7'h78;
        return r;
    endfunction

    task automatic run(bit pres, logic [15:0] w0, logic [15:0] wv, logic [15:0] wp,
                       logic [15:0] wf, logic [15:0] wvol);
        bit          ok;
        bit          got;
        logic [15:0] held;
        for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;
        mem[0] = w0; mem[1] = wv; mem[2] = wp; mem[3] = wf; mem[4] = wvol;
        present = pres;
        rst_n   = 1'b0;
        repeat (4) @(negedge clk);
        ntx = 0; cmd_err = 0; order_err = 0; per_err = 0; gap_err = 0;
        // R1: reset state
        check("R1 done at reset", 32'(done), 32'd0);
        check("R1 vid at reset", 32'(vid), 32'h0D8C);
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        // R1: defaults held while loading
        check("R1 loading defaults",
              {vid, 5'(0), play_vol, 3'(0), done, mfr_str_en, ser_str_en, prod_str_en},
              {16'h0D8C, 5'(0), 7'h1E, 3'(0), 1'b0, 1'b1, 1'b0, 1'b1});
        got = 0;
        for (int i = 0; i < 20000 && !got; i++) begin
            @(negedge clk);
            if (done) got = 1;
        end
        if (!got) begin
            nvec++; nfail++;
            $display("FAIL R11 watchdog: done never rose actual=0 expected=1");
            return;
        end
        ok = pres && (w0[15:4] == 12'h670);
        // R4 R5 R6: identity and read count
        check("R6 vid", 32'(vid), ok ? 32'(wv) : 32'h0D8C);
        check("R6 pid", 32'(pid), ok ? 32'(wp) : 32'h0139);
        check(ok ? "R6 read count" : (pres ? "R4 read count" : "R5 read count"),
              32'(ntx), ok ? 32'd5 : 32'd1);
        // R7: string flags
        check("R7 string flags",
              {ser_data_valid, mfr_str_en, ser_str_en, prod_str_en},
              ok ? 32'(w0[3:0]) : 32'b0101);
        // R8: features
        check("R8 features", 32'(feat), ok ? 32'(wf[8:0] & 9'h1BF) : 32'h02A);
        // R9 R10: clamped volumes
        check("R9 playback volume", 32'(play_vol), ok ? 32'(play_exp(wvol)) : 32'h1E);
        check("R10 record volume", 32'(rec_vol), ok ? 32'(rec_exp(wvol)) : 32'h3C);
        // R2 R3 R6: protocol monitors
        check("R2 command framing", 32'(cmd_err), 32'd0);
        check("R6 address order", 32'(order_err), 32'd0);
        check("R3 clock period", 32'(per_err), 32'd0);
        check("R3 select gap", 32'(gap_err), 32'd0);
        held = vid;
        repeat (30) @(negedge clk);
        // R11: sticky and frozen
        check("R11 done sticky", 32'(done), 32'd1);
        check("R11 vid frozen", 32'(vid), 32'(held));
        check("R11 no further reads", {31'(0), ee_cs}, 32'd0);
    endtask

    function automatic logic [6:0] pv(int n);
        case (n % 8)
            0: return 7'h00;  1: return 7'h01;  2: return 7'h02;  3: return 7'h03;
            4: return 7'h49;  5: return 7'h4A;  6: return 7'h4B;  default: return 7'h7F;
        endcase
    endfunction

    function automatic logic [6:0] rv(int n);
        case (n % 5)
            0: return 7'h00;  1: return 7'h77;  2: return 7'h78;
            3: return 7'h79;  default: return 7'h7F;
        endcase
    endfunction

    initial begin
        // R5: empty socket
        run(1'b0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'h0000);
        // R4: wrong signatures
        run(1'b1, 16'h6807, 16'h1234, 16'h5678, 16'h01FF, 16'h2020);
        run(1'b1, 16'h671F, 16'h1234, 16'h5678, 16'h01FF, 16'h2020);
        run(1'b1, 16'h0670, 16'h1234, 16'h5678, 16'h01FF, 16'h2020);
        // R6..R10: every string nibble with volume edges
        for (int n = 0; n < 16; n++) begin
            run(1'b1, 16'h6700 | 16'(n),
                16'h1000 + 16'(n * 'h111),
                16'hF00F ^ 16'(n * 'h0321),
                16'hFFFF ^ 16'(n * 'h0123),
                {n[0], pv(n), n[1], rv(n)});
        end
        // R9 R10: remaining playback edges
        for (int n = 16; n < 24; n++) begin
            run(1'b1, 16'h6705, 16'hABCD, 16'h4321, 16'h0040, {1'b1, pv(n), 1'b1, rv(n + 1)});
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule